// File: doc/BRIEF.md
# Duty-Cycled Wake and Power Sequencer

This always-on controller keeps a sensing node asleep for most of each period and wakes it for a short active window. A wake has one of two causes. A period timer expires, or a sample arrives with its valid strobe and its value is above a programmed threshold. Once awake, the controller powers the processor and the sensor together and waits for processing to finish. It then powers the radio for the transmit phase only. It drops the radio, keeps the processor on for one wind-down cycle, and then turns everything off until the next wake.

The ratio of active time to total time follows from the programmed period and the length of the active window. The active window is bounded by each subsystem's done handshake and by a programmable per-phase timeout. The controller adapts its own wake period. It uses a fast period while threshold crossings keep occurring. It drops to a slow period only after a run of consecutive quiet wakes. Two counters record timer wakes and event wakes separately.

Top module: `dcw_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `proc_en`, `sensor_en`, `radio_en` and `awake` are 0. Both wake counters are 0 and `fast_mode` is 0.
- R2: With no threshold crossings, consecutive wakes start exactly P cycles apart. P is `slow_period` while `fast_mode` is 0 and `fast_period` while it is 1. Each of these wakes adds 1 to `timer_wakes`.
- R3: In a sleeping cycle where `sample_valid` is 1 and `sample` is strictly greater than `threshold` (both compared as unsigned), `awake` and `sensor_en` are 1 in the next cycle and `event_wakes` rises by 1. A sample equal to the threshold, or a sample presented with `sample_valid` low, causes no wake.
- R4: The sensing phase has `proc_en` and `sensor_en` at 1 and `radio_en` at 0, and it lasts until `proc_done` is sampled high. The transmit phase follows, with `proc_en` and `radio_en` at 1 and `sensor_en` at 0, and it lasts until `tx_done` is sampled high. After that comes one cycle with only `proc_en` at 1, and then all enables are 0.
- R5: `radio_en` is 1 only in the transmit phase. It is never 1 together with `sensor_en`, and it only rises directly after a sensing cycle.
- R6: If a phase's done handshake does not arrive, the phase lasts max(`wait_timeout`,1) cycles. In the next cycle all enables are 0 and the node is asleep.
- R7: A threshold crossing that arrives during an active window is held. After the window ends the node sleeps for exactly one cycle and then starts an event wake.
- R8: A wake is active when its interval contained a crossing, including the crossing that caused the wake. At an active wake `fast_mode` becomes 1. At the QUIET_N-th consecutive quiet wake (default 3) `fast_mode` becomes 0.
- R9: The period timer reloads at the start of every wake, event wakes included, with the period selected by the value `fast_mode` takes at that wake.
- R10: Every wake adds 1 to exactly one of `timer_wakes` and `event_wakes`. A wake counts as an event wake when a crossing is pending or present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_period | input | CNT_W | Wake period in cycles while activity is detected |
| slow_period | input | CNT_W | Wake period in cycles while the input is quiet |
| threshold | input | SAMPLE_W | Event threshold, compared unsigned |
| wait_timeout | input | TO_W | Maximum cycles in each wait phase |
| sample | input | SAMPLE_W | Sensor sample value |
| sample_valid | input | 1 | Sample strobe |
| proc_done | input | 1 | Sampling and processing finished |
| tx_done | input | 1 | Transmission finished |
| proc_en | output | 1 | Processor power enable |
| sensor_en | output | 1 | Sensor power enable |
| radio_en | output | 1 | Radio power enable |
| awake | output | 1 | Active window in progress |
| fast_mode | output | 1 | Fast wake period selected |
| timer_wakes | output | STAT_W | Count of timer-caused wakes |
| event_wakes | output | STAT_W | Count of threshold-caused wakes |

## Verification
The hardest situation to reach is the rate change. It needs an event wake followed by exactly QUIET_N quiet timer wakes, and the period in each interval must then be measured. The bench triggers a single crossing while the node is asleep. With an automatic done responder running, it timestamps each rising edge of `awake` and compares every interval against the fast or slow period in force. The held event is reached by presenting a crossing in the middle of a manually handshaken sensing phase.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_SENSE = 2'd1,
        ST_TX    = 2'd2,
        ST_WIND  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic proc;
        logic sensor;
        logic radio;
    } pwr_en_t;

    // Power enables seen in each sequencer state.
    function automatic pwr_en_t state_enables(seq_state_e s);
        pwr_en_t e;
        e.proc   = (s != ST_SLEEP);
        e.sensor = (s == ST_SENSE);
        e.radio  = (s == ST_TX);
        return e;
    endfunction

    localparam int NUM_CAUSES = 2;
    localparam int CAUSE_TIMER = 0;
    localparam int CAUSE_EVENT = 1;

endpackage

// File: rtl/dcw_period_timer.sv
module dcw_period_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] period,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;
    logic [CNT_W-1:0] load_v;

    // A period of zero behaves as one cycle.
    assign load_v = (period == '0) ? '0 : period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            primed_q <= 1'b0;
        end else if (!primed_q || reload) begin
            cnt_q    <= load_v;
            primed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = primed_q && (cnt_q == '0);
endmodule

// File: rtl/dcw_event_detect.sv
module dcw_event_detect #(
    parameter int SAMPLE_W = 12,
    parameter int QUIET_N  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic                asleep,
    input  logic                wake_start,
    output logic                event_req,
    output logic                fast_q,
    output logic                fast_next
);
    localparam int QW = $clog2(QUIET_N + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUIET_N);

    logic          hit;
    logic          pend_q;
    logic          seen_q;
    logic [QW-1:0] quiet_q;
    logic [QW-1:0] quiet_next;
    logic          active_now;

    assign hit        = sample_valid && (sample > threshold);
    assign event_req  = hit || pend_q;
    assign active_now = hit || pend_q || seen_q;
    assign quiet_next = active_now ? '0 :
                        (quiet_q == QMAX) ? QMAX : quiet_q + 1'b1;

    always_comb begin
        if (active_now)
            fast_next = 1'b1;
        else if (quiet_next == QMAX)
            fast_next = 1'b0;
        else
            fast_next = fast_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            seen_q  <= 1'b0;
            quiet_q <= QMAX;
            fast_q  <= 1'b0;
        end else begin
            if (hit && !asleep)
                pend_q <= 1'b1;
            else if (wake_start)
                pend_q <= 1'b0;

            if (wake_start) begin
                seen_q  <= 1'b0;
                quiet_q <= quiet_next;
                fast_q  <= fast_next;
            end else if (hit) begin
                seen_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcw_power_fsm.sv
module dcw_power_fsm
    import dcw_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wake_req,
    input  logic            proc_done,
    input  logic            tx_done,
    input  logic [TO_W-1:0] wait_timeout,
    output seq_state_e      state,
    output logic            wake_start
);
    seq_state_e      state_q;
    logic [TO_W-1:0] wcnt_q;
    logic [TO_W-1:0] limit;
    logic            expire;

    assign limit      = (wait_timeout == '0) ? '0 : wait_timeout - 1'b1;
    assign expire     = (wcnt_q >= limit);
    assign wake_start = (state_q == ST_SLEEP) && wake_req;
    assign state      = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SLEEP;
            wcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    wcnt_q <= '0;
                    if (wake_req) state_q <= ST_SENSE;
                end
                ST_SENSE: begin
                    if (proc_done) begin
                        state_q <= ST_TX;
                        wcnt_q  <= '0;
                    end else if (expire) begin
                        state_q <= ST_SLEEP;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_TX: begin
                    if (tx_done) begin
                        state_q <= ST_WIND;
                    end else if (expire) begin
                        state_q <= ST_SLEEP;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_SLEEP;
            endcase
        end
    end
endmodule

// File: rtl/dcw_wake_stats.sv
module dcw_wake_stats
    import dcw_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_start,
    input  logic              is_event,
    output logic [STAT_W-1:0] timer_cnt,
    output logic [STAT_W-1:0] event_cnt
);
    logic [NUM_CAUSES-1:0] bump;
    logic [STAT_W-1:0]     cnt_q [NUM_CAUSES];

    assign bump[CAUSE_TIMER] = wake_start && !is_event;
    assign bump[CAUSE_EVENT] = wake_start && is_event;

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (bump[g])
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    assign timer_cnt = cnt_q[CAUSE_TIMER];
    assign event_cnt = cnt_q[CAUSE_EVENT];
endmodule

// File: rtl/dcw_sequencer.sv
module dcw_sequencer
    import dcw_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SAMPLE_W = 12,
    parameter int TO_W     = 16,
    parameter int STAT_W   = 8,
    parameter int QUIET_N  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    fast_period,
    input  logic [CNT_W-1:0]    slow_period,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic [TO_W-1:0]     wait_timeout,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_valid,
    input  logic                proc_done,
    input  logic                tx_done,
    output logic                proc_en,
    output logic                sensor_en,
    output logic                radio_en,
    output logic                awake,
    output logic                fast_mode,
    output logic [STAT_W-1:0]   timer_wakes,
    output logic [STAT_W-1:0]   event_wakes
);
    seq_state_e       state;
    pwr_en_t          en;
    logic             wake_start;
    logic             event_req;
    logic             timer_exp;
    logic             fast_next;
    logic             use_fast;
    logic [CNT_W-1:0] period_sel;

    // At a wake the new rate applies; otherwise the current one does.
    assign use_fast   = wake_start ? fast_next : fast_mode;
    assign period_sel = use_fast ? fast_period : slow_period;

    dcw_event_detect #(.SAMPLE_W(SAMPLE_W), .QUIET_N(QUIET_N)) u_evt (
        .clk          (clk),
        .rst          (rst),
        .sample       (sample),
        .sample_valid (sample_valid),
        .threshold    (threshold),
        .asleep       (state == ST_SLEEP),
        .wake_start   (wake_start),
        .event_req    (event_req),
        .fast_q       (fast_mode),
        .fast_next    (fast_next)
    );

    dcw_period_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .reload  (wake_start),
        .period  (period_sel),
        .expired (timer_exp)
    );

    dcw_power_fsm #(.TO_W(TO_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wake_req     (event_req || timer_exp),
        .proc_done    (proc_done),
        .tx_done      (tx_done),
        .wait_timeout (wait_timeout),
        .state        (state),
        .wake_start   (wake_start)
    );

    dcw_wake_stats #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .wake_start (wake_start),
        .is_event   (event_req),
        .timer_cnt  (timer_wakes),
        .event_cnt  (event_wakes)
    );

    assign en        = state_enables(state);
    assign proc_en   = en.proc;
    assign sensor_en = en.sensor;
    assign radio_en  = en.radio;
    assign awake     = (state != ST_SLEEP);
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
    parameter int SAMPLE_W = 12,
    parameter int STAT_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] threshold,
    input logic [SAMPLE_W-1:0] sample,
    input logic                sample_valid,
    input logic                proc_en,
    input logic                sensor_en,
    input logic                radio_en,
    input logic                awake,
    input logic [STAT_W-1:0]   timer_wakes,
    input logic [STAT_W-1:0]   event_wakes
);
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (!proc_en && !sensor_en && !radio_en && !awake));

    a_r5_radio_alone: assert property (@(posedge clk) disable iff (rst)
        radio_en |-> (proc_en && !sensor_en));

    a_r5_radio_after_sense: assert property (@(posedge clk) disable iff (rst)
        $rose(radio_en) |-> $past(sensor_en));

    a_r4_sensor_with_proc: assert property (@(posedge clk) disable iff (rst)
        sensor_en |-> proc_en);

    a_r3_event_wakes_now: assert property (@(posedge clk) disable iff (rst)
        (!awake && sample_valid && (sample > threshold)) |=> (awake && sensor_en));

    a_r10_one_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(awake) |->
            ((timer_wakes != $past(timer_wakes)) != (event_wakes != $past(event_wakes))));
endmodule

bind dcw_sequencer dcw_checker #(.SAMPLE_W(SAMPLE_W), .STAT_W(STAT_W)) u_dcw_chk (
    .clk          (clk),
    .rst          (rst),
    .threshold    (threshold),
    .sample       (sample),
    .sample_valid (sample_valid),
    .proc_en      (proc_en),
    .sensor_en    (sensor_en),
    .radio_en     (radio_en),
    .awake        (awake),
    .timer_wakes  (timer_wakes),
    .event_wakes  (event_wakes)
);

// File: tb/tb_dcw_sequencer.sv
module tb_dcw_sequencer;
    localparam int CNT_W = 16, SAMPLE_W = 12, TO_W = 16, STAT_W = 8, QUIET_N = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [CNT_W-1:0]    fast_period = 16'd1000;
    logic [CNT_W-1:0]    slow_period = 16'd1000;
    logic [SAMPLE_W-1:0] threshold = '1;
    logic [TO_W-1:0]     wait_timeout = 16'd100;
    logic [SAMPLE_W-1:0] sample = '0;
    logic                sample_valid = 1'b0;
    logic                proc_done = 1'b0;
    logic                tx_done = 1'b0;
    logic                proc_en, sensor_en, radio_en, awake, fast_mode;
    logic [STAT_W-1:0]   timer_wakes, event_wakes;

    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  auto_resp = 1'b0;
    bit  finished = 1'b0;
    logic awake_d = 1'b0;

    dcw_sequencer #(.CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W), .TO_W(TO_W),
                    .STAT_W(STAT_W), .QUIET_N(QUIET_N)) dut (
        .clk(clk), .rst(rst), .fast_period(fast_period), .slow_period(slow_period),
        .threshold(threshold), .wait_timeout(wait_timeout), .sample(sample),
        .sample_valid(sample_valid), .proc_done(proc_done), .tx_done(tx_done),
        .proc_en(proc_en), .sensor_en(sensor_en), .radio_en(radio_en),
        .awake(awake), .fast_mode(fast_mode),
        .timer_wakes(timer_wakes), .event_wakes(event_wakes));

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Automatic done responder: answers each phase one cycle after it starts.
    always @(negedge clk) begin
        if (auto_resp) begin
            proc_done = sensor_en;
            tx_done   = radio_en;
        end
        awake_d = awake;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Returns the cycle number of the next rising edge of awake.
    task automatic wait_wake(output int at);
        int guard = 0;
        at = -1;
        while (guard < 5000) begin
            @(negedge clk);
            if (awake && !awake_d) begin
                at = cyc;
                return;
            end
            guard++;
        end
        check(1'b0, "wake timeout", guard, 0);
    endtask

    task automatic wait_sleep();
        int guard = 0;
        while (awake && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic pulse_hit(input logic [SAMPLE_W-1:0] v);
        sample = v;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        check({proc_en, sensor_en, radio_en, awake} == 4'b0, "R1 enables in reset",
              {proc_en, sensor_en, radio_en, awake}, 0);
        rst = 1'b0;
        tick(1);
        check({proc_en, sensor_en, radio_en, awake} == 4'b0, "R1 enables after reset",
              {proc_en, sensor_en, radio_en, awake}, 0);
        check(timer_wakes == 0 && event_wakes == 0, "R1 counters", timer_wakes + event_wakes, 0);
        check(fast_mode == 1'b0, "R1 fast_mode", fast_mode, 0);
    endtask

    task automatic t_timer();
        int w1, w2, t0;
        auto_resp = 1'b1;
        slow_period = 16'd20;
        fast_period = 16'd8;
        threshold = '1;
        t0 = timer_wakes;
        wait_wake(w1);
        wait_wake(w2);
        check(w2 - w1 == 20, "R2 slow interval", w2 - w1, 20);
        check(timer_wakes - t0 == 2, "R2 R10 timer count", timer_wakes - t0, 2);
        check(event_wakes == 0, "R10 no event count", event_wakes, 0);
        check(fast_mode == 1'b0, "R8 stays slow when quiet", fast_mode, 0);
        wait_sleep();
        auto_resp = 1'b0;
        proc_done = 1'b0;
        tx_done = 1'b0;
        slow_period = 16'd1000;
        fast_period = 16'd1000;
    endtask

    task automatic t_event_and_sequence();
        int e0;
        tick(2);
        threshold = 12'd100;
        e0 = event_wakes;
        pulse_hit(12'd100);
        check(awake == 1'b0, "R3 equal sample ignored", awake, 0);
        sample = 12'd200;
        sample_valid = 1'b0;
        tick(1);
        check(awake == 1'b0, "R3 invalid sample ignored", awake, 0);
        pulse_hit(12'd200);
        check(awake && sensor_en && proc_en && !radio_en, "R3 R4 immediate wake in sense",
              {awake, proc_en, sensor_en, radio_en}, 4'b1110);
        check(event_wakes - e0 == 1, "R3 R10 event count", event_wakes - e0, 1);
        tick(3);
        check(sensor_en && !radio_en, "R4 holds sense without done",
              {sensor_en, radio_en}, 2'b10);
        proc_done = 1'b1;
        tick(1);
        proc_done = 1'b0;
        check(proc_en && radio_en && !sensor_en, "R4 R5 transmit phase",
              {proc_en, sensor_en, radio_en}, 3'b101);
        tick(2);
        check(radio_en == 1'b1, "R4 holds transmit without done", radio_en, 1);
        tx_done = 1'b1;
        tick(1);
        tx_done = 1'b0;
        check({proc_en, sensor_en, radio_en} == 3'b100, "R4 R5 wind-down",
              {proc_en, sensor_en, radio_en}, 3'b100);
        tick(1);
        check({proc_en, sensor_en, radio_en, awake} == 4'b0, "R4 all off",
              {proc_en, sensor_en, radio_en, awake}, 0);
    endtask

    task automatic t_timeout();
        int n = 0;
        bit saw_radio = 1'b0;
        wait_timeout = 16'd5;
        tick(2);
        pulse_hit(12'd300);
        while (sensor_en && n < 50) begin
            n++;
            saw_radio |= radio_en;
            tick(1);
        end
        check(n == 5, "R6 sense timeout length", n, 5);
        check(!saw_radio && !awake && !proc_en, "R6 R5 off after sense timeout",
              {saw_radio, awake, proc_en}, 0);
        tick(2);
        pulse_hit(12'd300);
        proc_done = 1'b1;
        tick(1);
        proc_done = 1'b0;
        n = 0;
        while (radio_en && n < 50) begin
            n++;
            tick(1);
        end
        check(n == 5, "R6 transmit timeout length", n, 5);
        check(!awake && !proc_en && !sensor_en, "R6 off after transmit timeout",
              {awake, proc_en, sensor_en}, 0);
        wait_timeout = 16'd100;
    endtask

    task automatic t_latched();
        int e0;
        tick(2);
        e0 = event_wakes;
        pulse_hit(12'd250);
        tick(1);
        pulse_hit(12'd250);
        check(sensor_en == 1'b1, "R7 hit arrived inside window", sensor_en, 1);
        proc_done = 1'b1;
        tick(1);
        proc_done = 1'b0;
        tx_done = 1'b1;
        tick(1);
        tx_done = 1'b0;
        tick(1);
        check(awake == 1'b0, "R7 one sleep cycle", awake, 0);
        tick(1);
        check(awake && sensor_en, "R7 held event wakes", {awake, sensor_en}, 2'b11);
        check(event_wakes - e0 == 2, "R7 R10 two event wakes", event_wakes - e0, 2);
        proc_done = 1'b1;
        tick(1);
        proc_done = 1'b0;
        tx_done = 1'b1;
        tick(1);
        tx_done = 1'b0;
        tick(2);
        check(awake == 1'b0, "R7 no third wake", awake, 0);
    endtask

    task automatic t_adaptive();
        int w0, w1, w2, w3, w4;
        fast_period = 16'd12;
        slow_period = 16'd40;
        auto_resp = 1'b1;
        wait_sleep();
        tick(1);
        pulse_hit(12'd500);
        w0 = cyc;
        check(fast_mode == 1'b1, "R8 fast after crossing", fast_mode, 1);
        wait_wake(w1);
        check(w1 - w0 == 12, "R9 event wake reloads fast period", w1 - w0, 12);
        check(fast_mode == 1'b1, "R8 fast after 1 quiet wake", fast_mode, 1);
        wait_wake(w2);
        check(w2 - w1 == 12 && fast_mode, "R8 fast after 2 quiet wakes", w2 - w1, 12);
        wait_wake(w3);
        check(w3 - w2 == 12, "R2 fast interval", w3 - w2, 12);
        check(fast_mode == 1'b0, "R8 slow after QUIET_N quiet wakes", fast_mode, 0);
        wait_wake(w4);
        check(w4 - w3 == 40, "R2 R9 slow interval after drop", w4 - w3, 40);
        wait_sleep();
        auto_resp = 1'b0;
    endtask

    initial begin
        t_reset();
        t_timer();
        t_event_and_sequence();
        t_timeout();
        t_latched();
        t_adaptive();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule